// File: doc/BRIEF.md
# SPI Slave Link Controller with Request Handshake

This block sits on the application side of a modem link. On that link the modem is the SPI master and this block is the slave. The slave cannot start a transfer on its own. It drives a request line high and waits for the master to select it. The block releases the request once the byte count of the transfer is reached, and it waits for the master to release the select before it takes the next step.

When the master pulls the select low without a request, that counts as an attention call and opens a session. Every session starts by reading a 4-byte header. The first 16-bit word of the header is a command that chooses what comes next: send the pending host data, receive data, or close the session. After a receive, the first word of the received data chooses the next step. After a send, the block reads another header. A transfer that has not finished within the configured timeout (2 s by default) is dropped and started again.

Host data reaches the block as a valid/ready byte stream. Received payload bytes leave it as a byte stream with a one-cycle valid strobe. The SPI pins are synchronized into the system clock, so SCLK must run well below the system clock.

Top module: `spi_req_link`

## Requirements
- R1: SPI mode 0. The block samples MOSI on the rising SCLK edge and changes MISO only after a falling edge. Bytes travel MSB first. The first bit of each transfer is on MISO before select is asserted.
- R2: The block starts a transfer by raising `req`. It raises `req` for a step while `cs_n` is still high.
- R3: `req` falls 4 system cycles after the last rising SCLK edge of the transfer's final byte. It stays low while `cs_n` remains low, and the next step begins only after `cs_n` goes high.
- R4: In idle, `req` stays low. A fall of `cs_n` in idle opens a session with a 4-byte header read. During the header read MISO carries 0x00 and nothing appears on the RX stream.
- R5: Header bytes 0 and 1 form the command word, low byte first. 0x0001 selects a send and 0x0000 selects a receive. 0x0002, or any other value, returns the block to idle with `req` low.
- R6: A send shifts out TX_BYTES payload bytes taken from the host stream in order, then 0xFF and 0xFF. The block then reads a header. `tx_ready` is high only while a payload byte is being taken.
- R7: A receive shifts in RX_BYTES bytes and presents each one, in order, on `rx_data` with a one-cycle `rx_valid`. Received bytes 0 and 1 form a word, low byte first. 0x0000 selects another receive, 0x0001 selects a send, and any other value selects a header read.
- R8: If a transfer is not complete TIMEOUT_US microseconds after `req` rose, the block drops `req`. It waits for `cs_n` high, raises `req` again and restarts the same transfer from its first byte.
- R9: A payload slot reached while `tx_valid` is low sends 0x00 and sets `tx_underrun`. The flag clears when the next send starts.
- R10: After reset, `req`, `miso`, `tx_ready`, `rx_valid` and `tx_underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from the master |
| cs_n | input | 1 | Active-low select from the master; also the attention signal |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| req | output | 1 | Transfer request to the master |
| tx_data | input | 8 | Host payload byte |
| tx_valid | input | 1 | Host payload byte available |
| tx_ready | output | 1 | Payload byte taken this cycle |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_underrun | output | 1 | A payload slot went out without host data |

## Verification
Each SCLK edge passes through two synchronizer flops and one edge-detect flop. A received byte therefore shows on `rx_valid` 3 cycles after its eighth rising edge. `req` falls 4 cycles after that edge, and MISO moves 3 cycles after a falling edge. The bench's master model holds each SCLK half period for 16 system cycles and does all its sampling on the falling system clock edge, so every result has settled before it is read. The timeout is measured as the number of cycles `req` stays high, which is due to equal the timeout count exactly, with one cycle of tolerance.

// File: rtl/spi_req_link.sv
module spi_req_link #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int TIMEOUT_US = 2_000_000,
  parameter int TX_BYTES   = 8,
  parameter int RX_BYTES   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       req,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       tx_underrun
);
  localparam int TO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int HDR_B  = 4;
  localparam int TX_TOT = TX_BYTES + 2;
  localparam int MAXB   = (TX_TOT > RX_BYTES) ? ((TX_TOT > HDR_B) ? TX_TOT : HDR_B)
                                              : ((RX_BYTES > HDR_B) ? RX_BYTES : HDR_B);
  localparam int CW     = $clog2(MAXB + 1);
  localparam int TW     = $clog2(TO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_REL, S_RETRY} st_t;
  typedef enum logic [1:0] {P_HDR, P_RX, P_TX} ph_t;

  logic [2:0]    sck_q;
  logic [1:0]    mosi_q, csn_q;
  st_t           st;
  ph_t           ph, nxt_ph;
  logic          nxt_go, primed;
  logic [2:0]    bitcnt;
  logic [7:0]    rxsh, txsh, w_lo;
  logic [15:0]   word;
  logic [CW-1:0] done_cnt, ld_cnt, total;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      csn_q  <= '1;
    end else begin
      sck_q  <= {sck_q[1:0], sclk};
      mosi_q <= {mosi_q[0], mosi};
      csn_q  <= {csn_q[0], cs_n};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_act   = ~csn_q[1];
  wire [7:0] rx_byte = {rxsh[6:0], mosi_q[1]};

  assign total = (ph == P_HDR) ? CW'(HDR_B) : (ph == P_RX) ? CW'(RX_BYTES) : CW'(TX_TOT);

  wire byte_done = (st == S_XFER) && primed && cs_act && sck_rise && (bitcnt == 3'd7);
  wire xfer_end  = (st == S_XFER) && primed && (done_cnt == total);
  wire timed_out = (st == S_XFER) && primed && (tmr == TW'(TO_CYC - 1));
  wire load_now  = (st == S_XFER) && !xfer_end &&
                   (!primed || (cs_act && sck_fall && ld_cnt == done_cnt && ld_cnt < total));
  wire pay_slot  = (ph == P_TX) && (ld_cnt < CW'(TX_BYTES));
  wire [7:0] ld_byte = pay_slot ? (tx_valid ? tx_data : 8'h00)
                                : ((ph == P_TX) ? 8'hFF : 8'h00);

  assign tx_ready = load_now && pay_slot;
  assign miso     = txsh[7];

  always_comb begin
    nxt_go = 1'b1;
    nxt_ph = P_HDR;
    case (ph)
      P_HDR:
        if (word == 16'h0001)      nxt_ph = P_TX;
        else if (word == 16'h0000) nxt_ph = P_RX;
        else                       nxt_go = 1'b0;
      P_RX:
        if (word == 16'h0000)      nxt_ph = P_RX;
        else if (word == 16'h0001) nxt_ph = P_TX;
      default:                     nxt_ph = P_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;  ph <= P_HDR;  primed <= 1'b0;  bitcnt <= '0;
      rxsh <= '0;  txsh <= '0;  w_lo <= '0;  word <= '0;
      done_cnt <= '0;  ld_cnt <= '0;  tmr <= '0;
      req <= 1'b0;  rx_data <= '0;  rx_valid <= 1'b0;  tx_underrun <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (cs_act) begin
            ph <= P_HDR;  st <= S_XFER;  primed <= 1'b0;
            done_cnt <= '0;  ld_cnt <= '0;  bitcnt <= '0;
          end
        S_XFER: begin
          if (!cs_act) bitcnt <= '0;
          else if (sck_rise) begin
            rxsh   <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
          end
          if (byte_done) begin
            done_cnt <= done_cnt + 1'b1;
            if (done_cnt == '0)      w_lo <= rx_byte;
            if (done_cnt == CW'(1))  word <= {rx_byte, w_lo};
            if (ph == P_RX) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_byte;
            end
          end
          if (!primed) begin
            primed <= 1'b1;
            req    <= 1'b1;
            tmr    <= '0;
            if (ph == P_TX) tx_underrun <= 1'b0;
          end else if (xfer_end) begin
            req <= 1'b0;
            st  <= S_REL;
          end else if (timed_out) begin
            req <= 1'b0;
            st  <= S_RETRY;
          end else tmr <= tmr + 1'b1;
          if (load_now) begin
            txsh   <= ld_byte;
            ld_cnt <= ld_cnt + 1'b1;
            if (pay_slot && !tx_valid) tx_underrun <= 1'b1;
          end else if (cs_act && sck_fall) txsh <= {txsh[6:0], 1'b0};
        end
        S_REL:
          if (!cs_act) begin
            if (nxt_go) begin
              ph <= nxt_ph;  st <= S_XFER;  primed <= 1'b0;
              done_cnt <= '0;  ld_cnt <= '0;  bitcnt <= '0;
            end else st <= S_IDLE;
          end
        default:
          if (!cs_act) begin
            st <= S_XFER;  primed <= 1'b0;
            done_cnt <= '0;  ld_cnt <= '0;  bitcnt <= '0;
          end
      endcase
    end
endmodule

module spi_req_link_chk #(
  parameter int TO_CYC = 1,
  parameter int CW     = 1,
  parameter int TW     = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          tx_ready,
  input logic          tx_valid,
  input logic          rx_valid,
  input logic          tx_underrun,
  input logic [1:0]    st,
  input logic [1:0]    ph,
  input logic          primed,
  input logic [CW-1:0] done_cnt,
  input logic [CW-1:0] total,
  input logic [TW-1:0] tmr
);
  AST_IDLE_NO_REQ:   assert property (@(posedge clk) disable iff (!rst_n) st == 2'd0 |-> !req);                                   // R4
  AST_REQ_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd1 && primed && done_cnt == total) |=> !req); // R3
  AST_NO_OVERCOUNT:  assert property (@(posedge clk) disable iff (!rst_n) st == 2'd1 |-> done_cnt <= total);                    // R3
  AST_TIMER_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) st == 2'd1 |-> tmr < TW'(TO_CYC));                    // R8
  AST_RETRY_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n) st == 2'd3 |-> !req);                                  // R8
  AST_TXRDY_IN_SEND: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> ph == 2'd2);                               // R6
  AST_RXV_IN_RECV:   assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> ph == 2'd1);                               // R7
  AST_UNDERRUN_WHY:  assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_underrun) |-> $past(tx_ready && !tx_valid));  // R9
endmodule

bind spi_req_link spi_req_link_chk #(.TO_CYC(TO_CYC), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .rx_valid(rx_valid), .tx_underrun(tx_underrun), .st(st), .ph(ph), .primed(primed),
  .done_cnt(done_cnt), .total(total), .tmr(tmr)
);

// File: tb/sim_spi_req_link.sv
module sim_spi_req_link;
  localparam int TXB = 3;
  localparam int RXB = 4;
  localparam int TO  = 3000;

  logic clk = 0, rst_n = 0, sclk = 0, mosi = 0, cs_n = 1, tx_valid = 0;
  logic [7:0] tx_data = 8'hA0;
  logic miso, req, tx_ready, rx_valid, tx_underrun;
  logic [7:0] rx_data;

  spi_req_link #(.CLK_HZ(125_000_000), .TIMEOUT_US(24), .TX_BYTES(TXB), .RX_BYTES(RXB)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .req(req),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_underrun(tx_underrun));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0, rx_total = 0;
  logic [7:0] rx_log [0:255];
  logic [7:0] got [0:7];
  logic [7:0] sent [0:7];
  logic [7:0] exp_tx = 8'hA0;

  // kind [19:16]: 0 header, 1 receive, 2 send; [15:0] first word driven on MOSI
  localparam logic [19:0] VEC [9] = '{
    {4'd0, 16'h0000}, {4'd1, 16'h0000}, {4'd1, 16'h0001}, {4'd2, 16'h0000},
    {4'd0, 16'h0001}, {4'd2, 16'h0000}, {4'd0, 16'h0000}, {4'd1, 16'h0005},
    {4'd0, 16'h0002}};

  always @(negedge clk) if (rx_valid === 1'b1) begin
    rx_log[rx_total[7:0]] = rx_data;
    rx_total++;
  end

  initial forever begin
    @(negedge clk);
    if (tx_ready === 1'b1 && tx_valid) begin
      @(posedge clk);
      #1 tx_data = tx_data + 8'd1;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wait_req(input logic lvl, input int lim, output int n);
    n = 0;
    while (req !== lvl && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic spi_byte(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      repeat (16) @(negedge clk);
      i[b] = miso;
      sclk = 1;
      repeat (16) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic xfer(input bit attn, input int nb, input logic [15:0] w);
    int n; logic [7:0] o, i;
    if (attn) cs_n = 0;
    wait_req(1'b1, 400, n);
    chk(req === 1'b1, "R2 request raised", req, 1);
    cs_n = 0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      o = (k == 0) ? w[7:0] : (k == 1) ? w[15:8] : 8'(8'h5A + k);
      sent[k] = o;
      spi_byte(o, i);
      got[k] = i;
    end
    wait_req(1'b0, 40, n);
    chk(req === 1'b0, "R3 request dropped at count", req, 0);
    repeat (40) @(negedge clk);
    chk(req === 1'b0, "R3 waits for release", req, 0);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_idle(input string r);
    int hi = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (req === 1'b1) hi++; end
    chk(hi == 0, r, hi, 0);
  endtask

  task automatic check_send(input bit fed);
    for (int k = 0; k < TXB; k++)
      chk(got[k] == (fed ? 8'(exp_tx + k) : 8'h00), fed ? "R6 payload byte" : "R9 underrun byte",
          got[k], fed ? 8'(exp_tx + k) : 0);
    chk(got[TXB] == 8'hFF && got[TXB+1] == 8'hFF, "R6 terminator", {got[TXB], got[TXB+1]}, 16'hFFFF);
    if (fed) exp_tx = exp_tx + 8'(TXB);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, base, nb; logic [7:0] i; logic [3:0] kind; logic [15:0] w; bit ok;
    repeat (10) @(negedge clk);
    chk({req, miso, tx_ready, rx_valid, tx_underrun} == 5'b0, "R10 reset outputs",
        {req, miso, tx_ready, rx_valid, tx_underrun}, 0);
    rst_n = 1;
    tx_valid = 1;
    check_idle("R4 no request without attention");

    for (int s = 0; s < 9; s++) begin
      kind = VEC[s][19:16];
      w    = VEC[s][15:0];
      nb   = (kind == 0) ? 4 : (kind == 1) ? RXB : TXB + 2;
      base = rx_total;
      xfer(s == 0, nb, w);
      case (kind)
        4'd0: begin
          ok = 1;
          for (int k = 0; k < 4; k++) if (got[k] != 8'h00) ok = 0;
          chk(ok, "R4 header MISO zero", got[0], 0);
          chk(rx_total == base, "R4 header not forwarded", rx_total - base, 0);
        end
        4'd1: begin
          chk(rx_total - base == RXB, "R7 receive count", rx_total - base, RXB);
          for (int k = 0; k < RXB; k++)
            chk(rx_log[8'(base + k)] == sent[k], "R1 R7 received byte", rx_log[8'(base + k)], sent[k]);
        end
        default: check_send(1'b1);
      endcase
    end
    check_idle("R5 end command returns to idle");

    xfer(1'b1, 4, 16'h0003);
    check_idle("R5 unknown command returns to idle");

    tx_valid = 0;
    xfer(1'b1, 4, 16'h0001);
    xfer(1'b0, TXB + 2, 16'h0000);
    check_send(1'b0);
    chk(tx_underrun === 1'b1, "R9 underrun flag set", tx_underrun, 1);
    tx_valid = 1;
    xfer(1'b0, 4, 16'h0001);
    xfer(1'b0, TXB + 2, 16'h0000);
    check_send(1'b1);
    chk(tx_underrun === 1'b0, "R9 underrun flag cleared", tx_underrun, 0);
    xfer(1'b0, 4, 16'h0002);
    check_idle("R5 session closed");

    xfer(1'b1, 4, 16'h0000);
    wait_req(1'b1, 400, n);
    n = 0;
    while (req === 1'b1 && n < TO + 200) begin @(negedge clk); n++; end
    chk(n >= TO - 1 && n <= TO + 1, "R8 timeout length", n, TO);
    wait_req(1'b1, 50, n);
    chk(req === 1'b1, "R8 request raised again", req, 1);
    cs_n = 0;
    repeat (8) @(negedge clk);
    spi_byte(8'h11, i);
    wait_req(1'b0, TO + 200, n);
    chk(req === 1'b0, "R8 stalled transfer times out", req, 0);
    cs_n = 1;
    base = rx_total;
    xfer(1'b0, RXB, 16'h0005);
    chk(rx_total - base == RXB, "R8 transfer restarts whole", rx_total - base, RXB);
    chk(rx_log[8'(base)] == 8'h05, "R8 first byte after restart", rx_log[8'(base)], 5);
    xfer(1'b0, 4, 16'h0002);
    check_idle("R5 idle after retried session");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule